// File: doc/BRIEF.md
# Six-Bit Bidirectional GPIO Port Controller

This block controls a small general-purpose I/O port of six pins behind a byte-wide, single-cycle register bus. Two registers are visible. A direction register decides, pin by pin, whether the output driver is on. A data latch holds the value driven on every pin whose driver is on. The pin side is modelled as three separate vectors: an enable for each output driver, a value for each output, and the pin level coming in.

Reading the data register gives, for each bit, the latch when that pin is an output and the synchronized pin level when it is an input. The latch takes every write, whatever the direction bits say. Software can therefore load the value first and then turn on the driver, so the pin never shows a stale level.

Top module: `gpio_port6`

## Requirements
- R1: After reset, all output enables are 0, all output values are 0, and the direction register reads 0x00.
- R2: A write to address 0x05 stores bits 5..0 as the direction bits. A read of 0x05 returns the stored bits, with bits 7..6 always 0.
- R3: Output enable bit i equals direction bit i, and output value bit i equals latch bit i. Both change at the clock edge that takes the write strobe and are visible in the cycle after it.
- R4: A write to address 0x01 updates the data latch whatever the direction bits are.
- R5: On a read of address 0x01, every bit whose direction bit is 1 returns the latch bit, whatever the pin level.
- R6: On a read of address 0x01, every bit whose direction bit is 0 returns the pin level after a two-stage synchronizer. A change on the pin shows on reads after the second rising edge.
- R7: Bits 7..6 of a data register read are always 0.
- R8: A read of any address other than 0x01 or 0x05 returns 0x00. A write to such an address changes neither register.
- R9: The read data output is 0x00 whenever no read is strobed (`bus_sel` low, or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read strobe |
| pin_in | input | 6 | Level sampled from the pins |
| pin_oe | output | 6 | Output driver enable per pin |
| pin_out | output | 6 | Output value per pin |

## Verification
The bench uses the default parameters: six pins, an eight-bit bus, two synchronizer stages and the register addresses 0x01 and 0x05. Because there are two spare bits above the six pins, the bench can write ones into those bits and confirm they read back as 0. The two-stage synchronizer gives a short latency, so the bench can check a pin change on the exact read before and after it shows up. Mixed direction masks let a single read return latch bits and pin bits side by side.

// File: rtl/gpio_port6.sv
module gpio_port6 #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PINS        = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);

  localparam int PAD = DATA_W - PINS;

  logic [PINS-1:0] dir_q, latch_q;
  logic [PINS-1:0] sync_q [SYNC_STAGES];

  wire hit_data = bus_addr == DATA_ADDR;
  wire hit_dir  = bus_addr == DIR_ADDR;
  wire wr_en    = bus_sel && bus_wr;
  wire rd_en    = bus_sel && !bus_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else if (wr_en) begin
      if (hit_dir)  dir_q   <= bus_wdata[PINS-1:0];
      if (hit_data) latch_q <= bus_wdata[PINS-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
  end

  wire [PINS-1:0] port_view = (dir_q & latch_q) | (~dir_q & sync_q[SYNC_STAGES-1]);

  assign pin_oe  = dir_q;
  assign pin_out = latch_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_en && hit_data) bus_rdata = {{PAD{1'b0}}, port_view};
    else if (rd_en && hit_dir) bus_rdata = {{PAD{1'b0}}, dir_q};
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0)); // R1

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_dir) |=> pin_oe == $past(bus_wdata[PINS-1:0])); // R3

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_data) |=> pin_out == $past(bus_wdata[PINS-1:0])); // R4

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (hit_data || hit_dir)) |=> ($stable(pin_oe) && $stable(pin_out))); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PINS] == '0); // R7

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> bus_rdata == '0); // R9

  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_dir) |-> bus_rdata[PINS-1:0] == pin_oe); // R2

endmodule

// File: tb/test_gpio_port6.sv
module test_gpio_port6;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;
  // row: {is_read, addr[7:0], wdata[7:0], pins[5:0], expect[7:0]}
  localparam logic [30:0] TBL [N] = '{
    {1'b0, 8'h05, 8'h00, 6'h2A, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h2A, 8'h2A},
    {1'b0, 8'h01, 8'h15, 6'h2A, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h2A, 8'h2A},
    {1'b0, 8'h05, 8'h0F, 6'h30, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h30, 8'h35},
    {1'b1, 8'h05, 8'h00, 6'h30, 8'h0F},
    {1'b0, 8'h05, 8'hFF, 6'h30, 8'h00},
    {1'b1, 8'h05, 8'h00, 6'h30, 8'h3F},
    {1'b1, 8'h01, 8'h00, 6'h00, 8'h15},
    {1'b0, 8'h01, 8'hFF, 6'h00, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h00, 8'h3F},
    {1'b0, 8'h05, 8'h00, 6'h11, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h11, 8'h11},
    {1'b1, 8'h03, 8'h00, 6'h11, 8'h00},
    {1'b0, 8'h02, 8'hFF, 6'h11, 8'h00},
    {1'b1, 8'h05, 8'h00, 6'h11, 8'h00},
    {1'b1, 8'h01, 8'h00, 6'h11, 8'h11}
  };

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [5:0] pin_in = 0, pin_oe, pin_out;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_port6 i_gpio_port6 (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .pin_in, .pin_oe, .pin_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    logic [7:0] r;
    #(CLK_PERIOD*3) @(negedge clk);
    check("R1 oe", {2'b0, pin_oe}, 8'h00);
    check("R1 out", {2'b0, pin_out}, 8'h00);
    rst_n = 1;
    idle(1);
    rd(8'h05, r); check("R1 dir read", r, 8'h00);
    rd(8'h01, r); check("R1 R6 data read pins low", r, 8'h00);

    for (int k = 0; k < N; k++) begin
      pin_in = TBL[k][13:8];
      idle(2);
      if (TBL[k][30]) begin
        rd(TBL[k][29:22], r);
        check($sformatf("table row %0d (R2 R5 R6 R7 R8)", k), r, TBL[k][7:0]);
      end else wr(TBL[k][29:22], TBL[k][21:14]);
    end

    // R3 timing of outputs
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h05; bus_wdata = 8'h3C;
    #1 check("R3 oe before edge", {2'b0, pin_oe}, 8'h00);
    @(posedge clk); #1;
    check("R3 oe after edge", {2'b0, pin_oe}, 8'h3C);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    // R4 preload while inputs
    wr(8'h05, 8'h00);
    wr(8'h01, 8'h2A);
    check("R4 latch written with dir 0", {2'b0, pin_out}, 8'h2A);
    check("R3 oe cleared", {2'b0, pin_oe}, 8'h00);
    // R8 stray write
    wr(8'h09, 8'hFF);
    check("R8 out unchanged", {2'b0, pin_out}, 8'h2A);
    check("R8 oe unchanged", {2'b0, pin_oe}, 8'h00);
    // R6 synchronizer latency
    pin_in = 6'h00; idle(3);
    pin_in = 6'h3F;
    @(negedge clk);
    rd(8'h01, r); check("R6 after one edge", r, 8'h00);
    rd(8'h01, r); check("R6 after two edges", r, 8'h3F);
    // R5 outputs ignore pins
    wr(8'h05, 8'h3F);
    pin_in = 6'h15; idle(3);
    rd(8'h01, r); check("R5 latch not pins", r, 8'h2A);
    // R9 no strobe
    bus_addr = 8'h01; bus_sel = 0; #1 check("R9 idle rdata", bus_rdata, 8'h00);
    bus_sel = 1; bus_wr = 1; #1 check("R9 write rdata", bus_rdata, 8'h00);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule